// File: doc/BRIEF.md
# Spread-Spectrum Frequency Code Generator

This block produces the 5-bit frequency-select code for a digitally tuned switching oscillator. Code 0x00 selects the highest oscillator frequency (+25 %) and 0x1F the lowest (−20 %). The nominal frequency fosc corresponds to code 0x10. The code moves only on a cycle-start strobe, which arrives once per switching cycle of the main converter. The oscillator therefore changes frequency only at a cycle boundary.

There are three ways to produce the code. With frequency tuning enabled, a 5-bit trim value is passed straight through. With tuning off and spreading on, the code walks through a 16-level band from fosc (code 0x10, level 0) down to 0.8×fosc (code 0x1F, level 15). The walk is either a pseudo-random walk or a triangular sweep. In the pseudo-random walk, a 7-bit maximal-length LFSR picks the direction of each step. In the triangular sweep, an up/down counter bounces between the two ends of the band. In both spreading modes every step is exactly one level. With tuning and spreading both off, the code is the nominal 0x10.

The control is a five-state machine. `ST_NOMINAL` is the reset state and holds code 0x10. `ST_TRIM` forwards the trim value. `ST_WALK` is the pseudo-random walk. `ST_RISE` and `ST_FALL` are the two halves of the triangle. All transitions are taken on the strobe, with this priority: tune enable, then spread enable, then spread mode.
- Any state goes to `ST_TRIM` when the tune enable is 1.
- Any state goes to `ST_NOMINAL` when tune and spread are both 0.
- `ST_TRIM` or `ST_NOMINAL` enters level 0 when spreading turns on. It goes to `ST_WALK` if the mode is 0 and to `ST_RISE` if the mode is 1.
- `ST_RISE` goes to `ST_FALL` at level 15, and `ST_FALL` goes to `ST_RISE` at level 0.
- `ST_WALK` goes to `ST_RISE` when the mode becomes 1. At level 15 it goes to `ST_FALL` instead.
- `ST_RISE` or `ST_FALL` goes to `ST_WALK` when the mode becomes 0.

Top module: `ssfc_code_gen`

## Requirements
- R1: After reset the output code is 0x10 and the block is in the nominal state.
- R2: The output code changes only in the clock cycle that follows a cycle-start strobe. Between strobes it holds its value whatever the other inputs do.
- R3: When the tune enable is 1 at a strobe, the next code equals the 5-bit trim value, whatever the spread enable and the mode select are. The full range 0x00 to 0x1F is passed through.
- R4: When the tune enable and the spread enable are both 0 at a strobe, the next code is 0x10.
- R5: The first strobe with spreading active (tune enable 0, spread enable 1), after a strobe without it, gives code 0x10. This is level 0, the fosc end of the band.
- R6: While spreading is active, the code stays within 0x10 to 0x1F. The code equals 0x10 plus the level number.
- R7: While spreading stays active from one strobe to the next, the code moves by exactly one level in either mode. It never holds and never jumps.
- R8: In spreading, a code of 0x10 is always followed by 0x11, and a code of 0x1F is always followed by 0x1E.
- R9: With mode select 0, the direction of each step comes from a pseudo-random sequence. Over 200 consecutive strobes in the band interior, both upward and downward steps occur.
- R10: With mode select 1, the code sweeps 0x10, 0x11, …, 0x1F, 0x1E, …, 0x10, 0x11, … with a period of 30 strobes. No end level appears twice in a row.
- R11: Changing the mode select while spreading continues from the current level without restarting. A switch from the random walk to the triangle moves up one level, or down one level when at 0x1F, and the sweep continues in that direction.
- R12: Turning the tune enable on during spreading and then off again restarts the spread at code 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_strobe | input | 1 | One-clock pulse at the start of each main-converter switching cycle |
| tune_en | input | 1 | 1: output follows the trim value; has priority over spreading |
| spread_en | input | 1 | 1: spreading active (when tune_en is 0) |
| spread_mode | input | 1 | 0: pseudo-random walk, 1: triangular sweep |
| trim | input | 5 | Direct frequency code used when tune_en is 1 |
| freq_code | output | 5 | Frequency-select code to the oscillator |

## Verification
The hardest situation to reach from the ports is the random walk arriving at the 0x1F end of the band. Whether and when that happens depends on the LFSR sequence, which the ports do not expose. The stimulus does not wait for it. It drives the triangular sweep to 0x1F, which is fully predictable, and switches to mode 0 there. The next step must then be forced down to 0x1E, which exercises the walk's upper clamp. A switch at the midpoint of the walk back into triangle mode checks that the level is carried across the mode change in both directions.

// File: rtl/ssfc_pkg.sv
package ssfc_pkg;

    typedef enum logic [2:0] {
        ST_NOMINAL = 3'd0,
        ST_TRIM    = 3'd1,
        ST_WALK    = 3'd2,
        ST_RISE    = 3'd3,
        ST_FALL    = 3'd4
    } ssfc_state_e;

    function automatic logic is_spread(input ssfc_state_e s);
        return (s == ST_WALK) || (s == ST_RISE) || (s == ST_FALL);
    endfunction

endpackage

// File: rtl/ssfc_lfsr.sv
module ssfc_lfsr #(
    parameter int              WIDTH = 7,
    parameter logic [WIDTH-1:0] TAPS = 7'b1100000,
    parameter logic [WIDTH-1:0] SEED = 7'h01
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic dir_bit
);
    logic [WIDTH-1:0] sr_q;
    logic             feedback;

    assign feedback = ^(sr_q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= SEED;
        end else if (advance) begin
            sr_q <= {sr_q[WIDTH-2:0], feedback};
        end
    end

    assign dir_bit = sr_q[0];
endmodule

// File: rtl/ssfc_walk_step.sv
module ssfc_walk_step #(
    parameter int LEVELS  = 16,
    localparam int LVL_W  = $clog2(LEVELS)
) (
    input  logic [LVL_W-1:0] level,
    input  logic             go_up,
    output logic [LVL_W-1:0] next_level
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(LEVELS - 1);

    always_comb begin
        if (level == '0) begin
            next_level = LVL_W'(1);
        end else if (level == TOP) begin
            next_level = TOP - LVL_W'(1);
        end else if (go_up) begin
            next_level = level + LVL_W'(1);
        end else begin
            next_level = level - LVL_W'(1);
        end
    end
endmodule

// File: rtl/ssfc_tri_step.sv
module ssfc_tri_step #(
    parameter int LEVELS  = 16,
    localparam int LVL_W  = $clog2(LEVELS)
) (
    input  logic [LVL_W-1:0] level,
    input  logic             rising,
    output logic [LVL_W-1:0] next_level,
    output logic             next_rising
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(LEVELS - 1);

    always_comb begin
        if (rising) begin
            if (level == TOP) begin
                next_level  = TOP - LVL_W'(1);
                next_rising = 1'b0;
            end else begin
                next_level  = level + LVL_W'(1);
                next_rising = 1'b1;
            end
        end else begin
            if (level == '0) begin
                next_level  = LVL_W'(1);
                next_rising = 1'b1;
            end else begin
                next_level  = level - LVL_W'(1);
                next_rising = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ssfc_code_gen.sv
module ssfc_code_gen #(
    parameter int              CODE_W       = 5,
    parameter int              LEVELS       = 16,
    parameter int              LFSR_W       = 7,
    parameter logic [6:0]      LFSR_TAPS    = 7'b1100000,
    parameter logic [6:0]      LFSR_SEED    = 7'h01,
    parameter int              NOMINAL_CODE = 16,
    parameter int              BAND_BASE    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_strobe,
    input  logic              tune_en,
    input  logic              spread_en,
    input  logic              spread_mode,
    input  logic [CODE_W-1:0] trim,
    output logic [CODE_W-1:0] freq_code
);
    import ssfc_pkg::*;

    localparam int LVL_W = $clog2(LEVELS);

    ssfc_state_e      state_q, state_d;
    logic [LVL_W-1:0] level_q, level_d;
    logic             rnd_dir;
    logic [LVL_W-1:0] walk_lvl;
    logic [LVL_W-1:0] tri_lvl;
    logic             tri_up;

    ssfc_lfsr #(
        .WIDTH (LFSR_W),
        .TAPS  (LFSR_W'(LFSR_TAPS)),
        .SEED  (LFSR_W'(LFSR_SEED))
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (cyc_strobe),
        .dir_bit (rnd_dir)
    );

    ssfc_walk_step #(.LEVELS(LEVELS)) u_walk (
        .level      (level_q),
        .go_up      (rnd_dir),
        .next_level (walk_lvl)
    );

    ssfc_tri_step #(.LEVELS(LEVELS)) u_tri (
        .level       (level_q),
        .rising      (state_q != ST_FALL),
        .next_level  (tri_lvl),
        .next_rising (tri_up)
    );

    // next-state and next-level decision, taken only on a cycle strobe
    always_comb begin
        state_d = state_q;
        level_d = level_q;
        if (cyc_strobe) begin
            if (tune_en) begin
                state_d = ST_TRIM;
            end else if (!spread_en) begin
                state_d = ST_NOMINAL;
            end else begin
                unique case (state_q)
                    ST_NOMINAL, ST_TRIM: begin
                        level_d = '0;
                        state_d = spread_mode ? ST_RISE : ST_WALK;
                    end
                    ST_WALK, ST_RISE, ST_FALL: begin
                        if (spread_mode) begin
                            level_d = tri_lvl;
                            state_d = tri_up ? ST_RISE : ST_FALL;
                        end else begin
                            level_d = walk_lvl;
                            state_d = ST_WALK;
                        end
                    end
                    default: begin
                        state_d = ST_NOMINAL;
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NOMINAL;
            level_q <= '0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_code <= CODE_W'(NOMINAL_CODE);
        end else if (cyc_strobe) begin
            unique case (state_d)
                ST_TRIM:    freq_code <= trim;
                ST_NOMINAL: freq_code <= CODE_W'(NOMINAL_CODE);
                default:    freq_code <= CODE_W'(BAND_BASE) + CODE_W'(level_d);
            endcase
        end
    end
endmodule

// File: rtl/ssfc_code_gen_chk.sv
module ssfc_code_gen_chk #(
    parameter int CODE_W       = 5,
    parameter int LEVELS       = 16,
    parameter int NOMINAL_CODE = 16,
    parameter int BAND_BASE    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_strobe,
    input logic              tune_en,
    input logic              spread_en,
    input logic [CODE_W-1:0] trim,
    input logic [CODE_W-1:0] freq_code
);
    logic spreading;
    logic was_spreading;

    assign spreading = !tune_en && spread_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            was_spreading <= 1'b0;
        end else if (cyc_strobe) begin
            was_spreading <= spreading;
        end
    end

    // R2: code holds between strobes
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_strobe |=> $stable(freq_code));

    // R3: trim passes through
    a_r3_trim_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && tune_en) |=> freq_code == $past(trim));

    // R4: nominal code when idle
    a_r4_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && !tune_en && !spread_en) |=> freq_code == CODE_W'(NOMINAL_CODE));

    // R5: spread entry at top frequency
    a_r5_entry_level0: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && spreading && !was_spreading) |=> freq_code == CODE_W'(BAND_BASE));

    // R6: code stays in band
    a_r6_in_band: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && spreading) |=>
            (int'(freq_code) >= BAND_BASE) && (int'(freq_code) <= BAND_BASE + LEVELS - 1));

    // R7: single-level step
    a_r7_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && spreading && was_spreading) |=>
            (int'(freq_code) == int'($past(freq_code)) + 1) ||
            (int'(freq_code) + 1 == int'($past(freq_code))));

    // R8: clamp at both band ends
    a_r8_bottom_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && spreading && was_spreading && int'(freq_code) == BAND_BASE) |=>
            int'(freq_code) == BAND_BASE + 1);

    a_r8_top_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && spreading && was_spreading && int'(freq_code) == BAND_BASE + LEVELS - 1) |=>
            int'(freq_code) == BAND_BASE + LEVELS - 2);
endmodule

bind ssfc_code_gen ssfc_code_gen_chk #(
    .CODE_W       (CODE_W),
    .LEVELS       (LEVELS),
    .NOMINAL_CODE (NOMINAL_CODE),
    .BAND_BASE    (BAND_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_strobe (cyc_strobe),
    .tune_en    (tune_en),
    .spread_en  (spread_en),
    .trim       (trim),
    .freq_code  (freq_code)
);

// File: tb/ssfc_code_gen_test.sv
module ssfc_code_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_strobe = 1'b0;
    logic       tune_en = 1'b0;
    logic       spread_en = 1'b0;
    logic       spread_mode = 1'b0;
    logic [4:0] trim = 5'h10;
    logic [4:0] freq_code;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ssfc_code_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_strobe  (cyc_strobe),
        .tune_en     (tune_en),
        .spread_en   (spread_en),
        .spread_mode (spread_mode),
        .trim        (trim),
        .freq_code   (freq_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) cyc_strobe = 1'b1;
        @(negedge clk) cyc_strobe = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset code", int'(freq_code), 16);
    endtask

    task automatic t_trim();
        @(negedge clk);
        tune_en = 1'b1; spread_en = 1'b1; spread_mode = 1'b1; trim = 5'h05;
        repeat (3) @(negedge clk);
        check("R2 no change before strobe", int'(freq_code), 16);
        strobe();
        check("R3 trim 0x05 with spread ignored", int'(freq_code), 5);
        trim = 5'h1F; strobe();
        check("R3 trim 0x1F", int'(freq_code), 31);
        trim = 5'h00; spread_mode = 1'b0; strobe();
        check("R3 trim 0x00", int'(freq_code), 0);
        trim = 5'h0A;
        repeat (4) @(negedge clk);
        check("R2 trim change held until strobe", int'(freq_code), 0);
    endtask

    task automatic t_nominal();
        tune_en = 1'b0; spread_en = 1'b0; strobe();
        check("R4 nominal code", int'(freq_code), 16);
    endtask

    task automatic t_triangle();
        int lv = 0;
        bit up = 1'b1;
        int bad = 0;
        tune_en = 1'b0; spread_en = 1'b1; spread_mode = 1'b1; strobe();
        check("R5 triangle entry", int'(freq_code), 16);
        for (int i = 0; i < 62; i++) begin
            if (up) begin
                if (lv == 15) begin lv = 14; up = 1'b0; end else lv++;
            end else begin
                if (lv == 0) begin lv = 1; up = 1'b1; end else lv--;
            end
            strobe();
            if (int'(freq_code) != 16 + lv) begin
                bad++;
                $display("FAIL R10 step %0d: actual %0d expected %0d", i, freq_code, 16 + lv);
            end
        end
        check("R10 triangle sequence mismatches", bad, 0);
        check("R6 triangle end in band", int'(freq_code), 16 + lv);
    endtask

    task automatic t_random();
        int prev;
        int ups = 0;
        int downs = 0;
        int bad_step = 0;
        int bad_band = 0;
        int bad_turn = 0;
        spread_en = 1'b0; strobe();
        spread_en = 1'b1; spread_mode = 1'b0; strobe();
        check("R5 random entry", int'(freq_code), 16);
        prev = int'(freq_code);
        for (int i = 0; i < 300; i++) begin
            strobe();
            if (int'(freq_code) < 16 || int'(freq_code) > 31) bad_band++;
            if (int'(freq_code) == prev + 1) begin
                if (prev != 16) ups++;
            end else if (int'(freq_code) == prev - 1) begin
                if (prev != 31) downs++;
            end else bad_step++;
            if (prev == 16 && int'(freq_code) != 17) bad_turn++;
            if (prev == 31 && int'(freq_code) != 30) bad_turn++;
            prev = int'(freq_code);
        end
        check("R6 random band violations", bad_band, 0);
        check("R7 random non-unit steps", bad_step, 0);
        check("R8 random bottom/top turn errors", bad_turn, 0);
        check("R9 upward steps seen", int'(ups > 0), 1);
        check("R9 downward steps seen", int'(downs > 0), 1);
    endtask

    task automatic t_switch();
        int lv;
        spread_en = 1'b0; strobe();
        spread_en = 1'b1; spread_mode = 1'b1; strobe();
        for (int i = 0; i < 15; i++) strobe();
        check("R10 triangle reaches top", int'(freq_code), 31);
        spread_mode = 1'b0; strobe();
        check("R8 walk forced down from 0x1F", int'(freq_code), 30);
        for (int i = 0; i < 7; i++) strobe();
        lv = int'(freq_code) - 16;
        spread_mode = 1'b1; strobe();
        check("R11 switch to triangle moves up", int'(freq_code), 16 + ((lv == 15) ? 14 : lv + 1));
        lv = int'(freq_code) - 16;
        if (lv != 15) begin
            strobe();
            check("R11 triangle continues upward", int'(freq_code), 16 + lv + 1);
        end
        tune_en = 1'b1; trim = 5'h03; strobe();
        check("R12 tune overrides spread", int'(freq_code), 3);
        spread_mode = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 hold while idle", int'(freq_code), 3);
        tune_en = 1'b0; strobe();
        check("R12 spread restarts at 0x10", int'(freq_code), 16);
        strobe();
        check("R8 first walk step goes up", int'(freq_code), 17);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_trim();
        t_nominal();
        t_triangle();
        t_random();
        t_switch();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule